// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One 16-bit down-counting channel of an interval timer. Counting advances only in cycles where the counting enable `cnt_en` is high. A one-cycle `load` strobe delivers a reload value and a 3-bit operating mode. The next counting cycle after the strobe starts the channel from that value, except in the gate-triggered modes, which wait for a rising edge on `gate`.

Six behaviours are offered:
- Mode 0: an output that goes low on load and rises at terminal count.
- Mode 1: a gate-triggered one-shot.
- Mode 2: a periodic rate generator.
- Mode 3: a square-wave generator that steps by two per counting cycle.
- Mode 4: a software-started single strobe.
- Mode 5: a gate-started single strobe.

`count_o` carries the live count in every cycle. Sampling it never disturbs the channel.

`load` is a plain control strobe and not a stream handshake. It is accepted in the cycle it is high and cannot be refused, so it has no back-pressure. The gate and the counting enable are level inputs.

Top module: `pict_channel`

## Requirements
- R1: After reset, `count_o` is 0, `out_o` is high and the channel does not count until it is loaded.
- R2: A `load` is applied at once. The count is unchanged until the next cycle with `cnt_en` high, and that cycle sets it to the reload value. Cycles with `cnt_en` low never change the count. While a channel waits for its start, `out_o` is low in mode 0 and high in every other mode.
- R3: In modes 0, 1, 4 and 5 each counting cycle lowers the count by exactly one, wrapping from 0 to 65535. A reload value of 0 stands for 65536 in every mode.
- R4: In mode 0, `out_o` is low from the load until the count reaches 0. It then stays high.
- R5: Mode 1 starts only on a rising edge of `gate`. `out_o` goes low at the start and rises when the count reaches 0. A later rising edge restarts the count from the reload value.
- R6: In modes 4 and 5, `out_o` goes low for one counting cycle when the count first reaches 0 after a start, and is high otherwise. Mode 4 starts on load. Mode 5 starts on a rising edge of `gate` and restarts on each later one.
- R7: Mode 2 counts N, N-1, ... 1 and then reloads N, so its period is N counting cycles. `out_o` is low exactly while the count is 1. A low `gate` holds the count, and a rising edge restarts it from N.
- R8: Mode 3 (N of at least 2) steps the count down by two. For even N the loaded value is N. For odd N it is N+1 in the high half and N-1 in the low half. Each half ends when the count reaches 2, so `out_o` is high for ceil(N/2) and low for floor(N/2) counting cycles. A low `gate` holds the count, and a rising edge restarts it high.
- R9: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R10: When `load` and a rising `gate` edge fall in the same cycle, the load wins and the edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting enable, one counting step per high cycle |
| gate | input | 1 | Gate level; its rising edge triggers and its low level suspends, depending on the mode |
| load | input | 1 | Strobe that takes `load_val` and `load_mode` |
| load_val | input | 16 | Reload value, 0 meaning 65536 |
| load_mode | input | 3 | Operating mode code, 0 to 7 |
| count_o | output | 16 | Live count |
| out_o | output | 1 | Output pin level |

## Verification
The bench targets the points where one cycle or one count is easily lost:
- The first counting cycle after a load. A design that loads at once, or one that counts during the load cycle, shifts every following output edge by one step.
- Odd square-wave periods. Splitting them evenly, or giving the extra step to the low half, leaves `out_o` low one cycle early.
- The reload value of 0 in strobe mode, which must give a strobe after 65536 counting cycles and never again. A design that strobes on every wrap is caught here.
- Gate suspension and retriggering in modes 1, 2, 3 and 5, and a gate edge that coincides with a load. Mishandling these shows up as a count that keeps moving while the gate is low, or as a restart that should not happen.

// File: rtl/pict_pkg.sv
package pict_pkg;

  typedef enum logic [2:0] {
    PM_TC_INT    = 3'd0,
    PM_ONE_SHOT  = 3'd1,
    PM_RATE      = 3'd2,
    PM_SQUARE    = 3'd3,
    PM_SW_STROBE = 3'd4,
    PM_HW_STROBE = 3'd5
  } pict_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic pict_mode_e fold_mode(input logic [2:0] code);
    if (code[1]) return pict_mode_e'({1'b0, code[1:0]});
    return pict_mode_e'(code);
  endfunction

  // modes where a rising gate edge (re)starts the count
  function automatic logic gate_restarts(input pict_mode_e m);
    return (m == PM_ONE_SHOT) || (m == PM_RATE) ||
           (m == PM_SQUARE)   || (m == PM_HW_STROBE);
  endfunction

  // modes where a low gate freezes the count
  function automatic logic gate_suspends(input pict_mode_e m);
    return (m == PM_RATE) || (m == PM_SQUARE);
  endfunction

  // modes that start on load rather than on a gate edge
  function automatic logic starts_on_load(input pict_mode_e m);
    return !((m == PM_ONE_SHOT) || (m == PM_HW_STROBE));
  endfunction

endpackage

// File: rtl/pict_gate_edge.sv
module pict_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/pict_start_val.sv
module pict_start_val
  import pict_pkg::*;
#(
  parameter int W = 16
) (
  input  pict_mode_e     mode,
  input  logic [W-1:0]   reload,
  input  logic           high_half,
  output logic [W-1:0]   start
);
  localparam logic [W-1:0] ONE = W'(1);

  // square mode with an odd reload: the high half takes one step more
  always_comb begin
    start = reload;
    if (mode == PM_SQUARE && reload[0]) begin
      start = high_half ? (reload + ONE) : (reload - ONE);
    end
  end
endmodule

// File: rtl/pict_step.sv
module pict_step
  import pict_pkg::*;
#(
  parameter int W = 16
) (
  input  pict_mode_e     mode,
  input  logic [W-1:0]   count,
  input  logic [W-1:0]   reload,
  input  logic           out_q,
  input  logic           fired_q,
  output logic [W-1:0]   nxt_count,
  output logic           nxt_out,
  output logic           nxt_fired
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] restart;

  // after a square half ends, the new phase is the opposite of out_q
  pict_start_val #(.W(W)) u_restart (
    .mode      (mode),
    .reload    (reload),
    .high_half (~out_q),
    .start     (restart)
  );

  always_comb begin
    nxt_count = count - ONE;
    nxt_out   = out_q;
    nxt_fired = fired_q;
    case (mode)
      PM_TC_INT, PM_ONE_SHOT: begin
        if (count == ONE) nxt_out = 1'b1;
      end
      PM_SW_STROBE, PM_HW_STROBE: begin
        nxt_out = 1'b1;
        if (count == ONE && !fired_q) begin
          nxt_out   = 1'b0;
          nxt_fired = 1'b1;
        end
      end
      PM_RATE: begin
        if (count == ONE) begin
          nxt_count = restart;
          nxt_out   = 1'b1;
        end else begin
          nxt_out = (count != TWO);
        end
      end
      PM_SQUARE: begin
        nxt_count = count - TWO;
        if (count == TWO) begin
          nxt_count = restart;
          nxt_out   = ~out_q;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pict_channel.sv
module pict_channel
  import pict_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic [2:0]       load_mode,
  output logic [WIDTH-1:0] count_o,
  output logic             out_o
);
  pict_mode_e       mode_q;
  pict_mode_e       new_mode;
  logic [WIDTH-1:0] reload_q;
  logic [WIDTH-1:0] count_q;
  logic             out_q;
  logic             run_q;
  logic             pend_q;
  logic             fired_q;
  logic             gate_rise;
  logic [WIDTH-1:0] first_val;
  logic [WIDTH-1:0] step_count;
  logic             step_out;
  logic             step_fired;
  logic             may_count;

  assign new_mode = fold_mode(load_mode);

  pict_gate_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  pict_start_val #(.W(WIDTH)) u_first (
    .mode      (mode_q),
    .reload    (reload_q),
    .high_half (1'b1),
    .start     (first_val)
  );

  pict_step #(.W(WIDTH)) u_step (
    .mode      (mode_q),
    .count     (count_q),
    .reload    (reload_q),
    .out_q     (out_q),
    .fired_q   (fired_q),
    .nxt_count (step_count),
    .nxt_out   (step_out),
    .nxt_fired (step_fired)
  );

  assign may_count = run_q && (gate || !gate_suspends(mode_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= PM_TC_INT;
      reload_q <= '0;
      count_q  <= '0;
      out_q    <= 1'b1;
      run_q    <= 1'b0;
      pend_q   <= 1'b0;
      fired_q  <= 1'b0;
    end else if (load) begin
      mode_q   <= new_mode;
      reload_q <= load_val;
      run_q    <= 1'b0;
      pend_q   <= starts_on_load(new_mode);
      out_q    <= (new_mode != PM_TC_INT);
      fired_q  <= 1'b0;
    end else begin
      if (cnt_en) begin
        if (pend_q) begin
          count_q <= first_val;
          run_q   <= 1'b1;
          pend_q  <= 1'b0;
          fired_q <= 1'b0;
          out_q   <= !((mode_q == PM_TC_INT) || (mode_q == PM_ONE_SHOT));
        end else if (may_count) begin
          count_q <= step_count;
          out_q   <= step_out;
          fired_q <= step_fired;
        end
      end
      if (gate_rise && gate_restarts(mode_q)) pend_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign out_o   = out_q;
endmodule

// File: rtl/pict_chk.sv
module pict_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         load,
  input logic [W-1:0] count_o,
  input logic         out_o,
  input logic [2:0]   mode,
  input logic         run,
  input logic         pend
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (out_o && count_o == '0));

  a_r2_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load) |=> $stable(count_o));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !load && run && !pend &&
     (mode == 3'd0 || mode == 3'd1 || mode == 3'd4 || mode == 3'd5))
    |=> count_o == W'($past(count_o) - W'(1)));

  a_r6_strobe_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_o && cnt_en && !load && !pend && (mode == 3'd4 || mode == 3'd5))
    |=> out_o);

  a_r7_low_only_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2 && !out_o) |-> count_o == W'(1));

  a_r8_even_count: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && run) |-> !count_o[0]);
endmodule

bind pict_channel pict_chk #(.W(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_en  (cnt_en),
  .load    (load),
  .count_o (count_o),
  .out_o   (out_o),
  .mode    (mode_q),
  .run     (run_q),
  .pend    (pend_q)
);

// File: tb/sim_pict_channel.sv
`timescale 1ns/1ps
module sim_pict_channel;
  logic        clk = 1'b0;
  logic        rst_n, cnt_en, gate, load;
  logic [15:0] load_val;
  logic [2:0]  load_mode;
  wire  [15:0] count_o;
  wire         out_o;

  always #5 clk = ~clk;

  pict_channel u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .load(load),
    .load_val(load_val), .load_mode(load_mode), .count_o(count_o), .out_o(out_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  string tag_over = "";

  // reference state, written from the requirements
  int m_mode = 0, m_n = 0, m_k = 0, m_held = 0;
  bit m_started = 0, m_pend = 0, m_idle_out = 1, m_gprev = 0;

  function automatic int neff();
    return (m_n == 0) ? 65536 : m_n;
  endfunction

  function automatic logic [15:0] exp_count();
    int e, p, h, hl, ll;
    if (!m_started) return 16'(m_held);
    e = neff();
    case (m_mode)
      2: begin p = m_k % e; return 16'(e - p); end
      3: begin
        h  = (e + 1) / 2;
        hl = (e % 2) ? e + 1 : e;
        ll = (e % 2) ? e - 1 : e;
        p  = m_k % e;
        if (p < h) return 16'(hl - 2 * p);
        return 16'(ll - 2 * (p - h));
      end
      default: return 16'(m_n - m_k);
    endcase
  endfunction

  function automatic logic exp_out();
    int e, p;
    if (!m_started) return m_idle_out;
    e = neff();
    case (m_mode)
      0, 1: return (m_k >= e);
      4, 5: return !(m_k == e);
      2: begin p = m_k % e; return !(p == e - 1 && e > 1); end
      default: begin p = m_k % e; return (p < (e + 1) / 2); end
    endcase
  endfunction

  function automatic string req_of(bit is_count);
    if (tag_over != "") return tag_over;
    if (!m_started) return "R2";
    case (m_mode)
      0: return is_count ? "R3" : "R4";
      1: return is_count ? "R3" : "R5";
      2: return "R7";
      3: return "R8";
      default: return is_count ? "R3" : "R6";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_update(bit ld, logic [15:0] lv, logic [2:0] lm, bit ce, bit g);
    bit rise;
    int nm;
    rise = g && !m_gprev;
    m_gprev = g;
    if (ld) begin
      nm = lm[1] ? int'(lm[1:0]) : int'(lm);
      m_held = int'(exp_count());
      m_mode = nm;
      m_n = int'(lv);
      m_started = 0;
      m_pend = !(nm == 1 || nm == 5);
      m_idle_out = (nm != 0);
    end else begin
      if (ce) begin
        if (m_pend) begin
          m_pend = 0; m_started = 1; m_k = 0;
        end else if (m_started && (g || !(m_mode == 2 || m_mode == 3))) begin
          m_k++;
        end
      end
      if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) m_pend = 1;
    end
  endtask

  task automatic step(bit ld, logic [15:0] lv, logic [2:0] lm, bit ce, bit g);
    @(negedge clk);
    load = ld; load_val = lv; load_mode = lm; cnt_en = ce; gate = g;
    model_update(ld, lv, lm, ce, g);
    @(posedge clk);
    #1;
    chk(req_of(1), "count", int'(count_o), int'(exp_count()));
    chk(req_of(0), "out", int'(out_o), int'(exp_out()));
  endtask

  task automatic run_n(int n, bit g);
    for (int i = 0; i < n; i++) step(0, 16'd0, 3'd0, 1, g);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    bit ld, ce, g;
    logic [15:0] lv;
    logic [2:0]  lm;
    void'($urandom(32'd4242));
    rst_n = 0; cnt_en = 0; gate = 0; load = 0; load_val = '0; load_mode = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset count", int'(count_o), 0);
    chk("R1", "reset out", int'(out_o), 1);
    @(negedge clk);
    rst_n = 1;
    tag_over = "R1";
    for (int i = 0; i < 3; i++) step(0, 16'd0, 3'd0, 1, 0);
    tag_over = "";

    // R2 / R4: mode 0, idle cycles, then terminal count
    step(1, 16'd5, 3'd0, 1, 0);
    step(0, 16'd0, 3'd0, 0, 0);
    step(0, 16'd0, 3'd0, 0, 0);
    run_n(8, 0);
    // R3: reload of 0 wraps
    step(1, 16'd0, 3'd0, 0, 0);
    run_n(4, 0);

    // R5: one-shot waits for the gate, then retriggers
    step(1, 16'd4, 3'd1, 1, 0);
    run_n(3, 0);
    run_n(3, 1);
    step(0, 16'd0, 3'd0, 1, 0);
    run_n(8, 1);

    // R6: hardware strobe
    step(1, 16'd3, 3'd5, 1, 0);
    run_n(2, 0);
    run_n(7, 1);
    step(0, 16'd0, 3'd0, 1, 0);
    run_n(6, 1);

    // R6 / R3: software strobe with reload 0 -> after 65536 steps, once
    step(1, 16'd0, 3'd4, 1, 0);
    run_n(65540, 0);

    // R10: load coinciding with a rising gate edge
    tag_over = "R10";
    step(1, 16'd4, 3'd2, 1, 1);
    tag_over = "";
    // R7: rate, suspension, restart
    run_n(10, 1);
    run_n(3, 0);
    run_n(7, 1);

    // R8: odd and even square waves with a pause
    step(1, 16'd5, 3'd3, 1, 1);
    run_n(14, 1);
    run_n(2, 0);
    run_n(9, 1);
    step(1, 16'd6, 3'd3, 1, 1);
    run_n(14, 1);

    // R9: codes 6 and 7
    tag_over = "R9";
    step(1, 16'd3, 3'd6, 1, 1);
    run_n(8, 1);
    step(1, 16'd7, 3'd7, 1, 1);
    run_n(16, 1);
    tag_over = "";

    // constrained random mix
    g = 1;
    for (int i = 0; i < 30000; i++) begin
      ld = ($urandom % 48) == 0;
      lv = ($urandom % 2) ? 16'($urandom_range(2, 40)) : 16'($urandom);
      lm = 3'($urandom % 8);
      if (lm[1] && lm[0] && lv < 16'd2) lv = 16'd2;
      ce = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) g = ~g;
      step(ld, lv, lm, ce, g);
    end

    finish_run();
  end
endmodule